// File: doc/BRIEF.md
# Three-Phase Sine-Triangle PWM Generator

This block drives a three-phase inverter from a symmetric triangle carrier and three sine references spaced a third of a cycle apart. A 16-bit angle is used throughout, so one full turn of the sine is 2^16 counts. Each phase's angle is the sum of four terms: a running position that advances once per carrier period, a power-angle shift, a fixed transformer correction and that phase's offset. The shift stays at zero for a programmable number of carrier periods after start and then ramps in fixed steps up to a target.

The work in each carrier period is split across the two turning points. At the carrier minimum the block captures the three angles. At the carrier maximum it looks the angles up in a sine table, scales each result by that phase's magnitude, maps it onto the carrier range and loads the three compare registers. A resync pulse clears the position so that the generated wave can be kept locked to an external reference. Deasserting enable, or asserting fault, forces all outputs low at once and returns the timing state to its start values.

Top module: `pwm3_top`

## Requirements
- R1: After reset, all three compare outputs read 0 and all three PWM outputs are low.
- R2: While running, the carrier counts 0,1,…,P,P-1,…,1,0,… (period 2P clocks, P = period_i). Each PWM output is high while the carrier is below that phase's compare value C. Over one carrier period this gives min(C,P)+max(C-1,0) high clocks.
- R3: The angle of phase k (k = 0,1,2, bit k of the PWM bus) is (pos + shift + 0x1555 + k*0x5555) mod 2^16. The sine table index is angle bits [15:8]. The table entry at index i is round(32767*sin(2*pi*i/256)), with halves rounded away from zero.
- R4: With h = P>>1, s the table value and m the unsigned magnitude of the phase, the compare value is h + ((((s*m)>>>15)*h)>>>15), with floor shifts, clamped to the range 0..P.
- R5: Angles are captured at the clock edge where the carrier is 0, and compare values are loaded only at the edge where the carrier equals P. After enable rises, the first load happens at the (P+1)th rising edge.
- R6: At every load, the position advances by step_i, wrapping at 16 bits. The first load after start uses position 0.
- R7: The shift is 0 for the first H loads after start (H = holdoff_i). From then on it rises by 64 at each load, capped at shift_tgt_i. Load n uses the shift reached after n-1 loads.
- R8: A clock with resync_i high clears the position to 0, overriding the step at that edge.
- R9: While en_i is low or fault_i is high, all PWM outputs are low in the same cycle. Position, shift, hold-off count and carrier return to their start values; the compare registers keep their contents.
- R10: After a start, the PWM outputs stay low until the first compare load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| fault_i | input | 1 | Shutdown request, forces outputs low |
| resync_i | input | 1 | Clears the sine position |
| period_i | input | 16 | Carrier peak value P (at least 2) |
| step_i | input | 16 | Position advance per carrier period |
| mag_i | input | 48 | Per-phase magnitude, phase k in bits [16k+15:16k], Q15 unsigned |
| shift_tgt_i | input | 16 | Final power-angle shift |
| holdoff_i | input | 16 | Carrier periods before the shift ramp starts |
| cmp_o | output | 48 | Compare values, phase k in bits [16k+15:16k] |
| pwm_o | output | 3 | PWM outputs, phase k on bit k |

## Verification
The assertions check the following on every cycle:
- outputs are low while the block is idle;
- the carrier stays within 0..P;
- compare registers and the shift change only at a carrier peak;
- a freshly loaded compare value never exceeds P;
- the position steps by exactly step_i at a peak and clears after resync.

The bench scenarios cover what needs a model of the angle arithmetic:
- the table values and scaling for each phase;
- clamping under overmodulation;
- the exact clock of the first load;
- the duty cycle over a carrier period;
- the hold-off length before the shift ramp starts;
- the restart after a fault.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int NPH = 3;

  // rounded Q15 sine sample of a table with 2**bits entries
  function automatic logic signed [15:0] sin_q15(input int idx, input int bits);
    real r;
    r = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(idx) / (2.0 ** bits));
    return 16'($rtoi(r >= 0.0 ? r + 0.5 : r - 0.5));
  endfunction
endpackage

// File: rtl/pwm3_sine_lut.sv
module pwm3_sine_lut #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic signed [15:0] val_o
);
  localparam int DEPTH = 2 ** IDX_W;
  logic signed [15:0] tbl [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tbl
    localparam logic signed [15:0] VAL = pwm3_pkg::sin_q15(gi, IDX_W);
    assign tbl[gi] = VAL;
  end

  assign val_o = tbl[idx_i];
endmodule

// File: rtl/pwm3_carrier.sv
module pwm3_carrier #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             valley_o,
  output logic             peak_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q >= period_i) begin
        up_q  <= 1'b0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        up_q  <= 1'b1;
        cnt_q <= CNT_W'(1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign valley_o = run_i && (cnt_q == '0);
  assign peak_o   = run_i && up_q && (cnt_q >= period_i);
endmodule

// File: rtl/pwm3_angle.sv
module pwm3_angle #(
  parameter int ANG_W      = 16,
  parameter int HOLD_W     = 16,
  parameter int SHIFT_STEP = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              peak_i,
  input  logic              resync_i,
  input  logic [ANG_W-1:0]  step_i,
  input  logic [ANG_W-1:0]  shift_tgt_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  output logic [ANG_W-1:0]  pos_o,
  output logic [ANG_W-1:0]  shift_o
);
  localparam logic [ANG_W-1:0] STEP_V = ANG_W'(SHIFT_STEP);

  logic [ANG_W-1:0]  pos_q;
  logic [ANG_W-1:0]  shift_q;
  logic [HOLD_W-1:0] hold_q;
  logic              ramp_ok;

  assign ramp_ok = peak_i && (hold_q >= holdoff_i) && (shift_q < shift_tgt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      shift_q <= '0;
      hold_q  <= '0;
    end else if (!run_i) begin
      pos_q   <= '0;
      shift_q <= '0;
      hold_q  <= '0;
    end else begin
      if (resync_i)    pos_q <= '0;
      else if (peak_i) pos_q <= pos_q + step_i;

      if (peak_i && (hold_q < holdoff_i)) hold_q <= hold_q + 1'b1;

      if (ramp_ok) begin
        if ((shift_tgt_i - shift_q) > STEP_V) shift_q <= shift_q + STEP_V;
        else                                  shift_q <= shift_tgt_i;
      end
    end
  end

  assign pos_o   = pos_q;
  assign shift_o = shift_q;
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int               CNT_W  = 16,
  parameter int               ANG_W  = 16,
  parameter int               IDX_W  = 8,
  parameter int               MAG_W  = 16,
  parameter logic [ANG_W-1:0] PH_OFS = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valley_i,
  input  logic             peak_i,
  input  logic             pwm_en_i,
  input  logic [ANG_W-1:0] base_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             pwm_o
);
  localparam int W1 = 16 + MAG_W + 1;
  localparam int W2 = W1 + CNT_W + 1;

  logic [IDX_W-1:0]     idx_q;
  logic signed [15:0]   sin_v;
  logic [CNT_W-1:0]     half;
  logic signed [W1-1:0] p1;
  logic signed [W2-1:0] p2;
  logic signed [W2-1:0] lvl;
  logic signed [W2-1:0] per_s;
  logic [CNT_W-1:0]     cmp_d;
  logic [CNT_W-1:0]     cmp_q;

  // only the table index of the angle is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (valley_i) idx_q <= IDX_W'((base_i + PH_OFS) >> (ANG_W - IDX_W));
  end

  pwm3_sine_lut #(.IDX_W(IDX_W)) u_lut (
    .idx_i(idx_q),
    .val_o(sin_v)
  );

  assign half  = period_i >> 1;
  assign p1    = W1'(sin_v) * W1'($signed({1'b0, mag_i}));
  assign p2    = W2'(p1 >>> 15) * W2'($signed({1'b0, half}));
  assign lvl   = W2'($signed({1'b0, half})) + (p2 >>> 15);
  assign per_s = W2'($signed({1'b0, period_i}));

  always_comb begin
    if (lvl < 0)          cmp_d = '0;
    else if (lvl > per_s) cmp_d = period_i;
    else                  cmp_d = lvl[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '0;
    else if (peak_i) cmp_q <= cmp_d;
  end

  assign cmp_o = cmp_q;
  assign pwm_o = pwm_en_i && (cnt_i < cmp_q);
endmodule

// File: rtl/pwm3_top.sv
module pwm3_top #(
  parameter int               CNT_W      = 16,
  parameter int               ANG_W      = 16,
  parameter int               IDX_W      = 8,
  parameter int               MAG_W      = 16,
  parameter int               HOLD_W     = 16,
  parameter int               SHIFT_STEP = 64,
  parameter logic [ANG_W-1:0] XFMR_SHIFT = 16'h1555
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic                           fault_i,
  input  logic                           resync_i,
  input  logic [CNT_W-1:0]               period_i,
  input  logic [ANG_W-1:0]               step_i,
  input  logic [pwm3_pkg::NPH*MAG_W-1:0] mag_i,
  input  logic [ANG_W-1:0]               shift_tgt_i,
  input  logic [HOLD_W-1:0]              holdoff_i,
  output logic [pwm3_pkg::NPH*CNT_W-1:0] cmp_o,
  output logic [pwm3_pkg::NPH-1:0]       pwm_o
);
  localparam int NPH = pwm3_pkg::NPH;
  localparam logic [ANG_W-1:0] PH_STEP = ANG_W'((2 ** ANG_W) / NPH);

  logic             run;
  logic             peak_w;
  logic             valley_w;
  logic [CNT_W-1:0] cnt_w;
  logic [ANG_W-1:0] pos_w;
  logic [ANG_W-1:0] shift_w;
  logic [ANG_W-1:0] base_w;
  logic             pwm_on_q;
  logic             pwm_en;

  assign run = en_i && !fault_i;

  pwm3_carrier #(.CNT_W(CNT_W)) u_car (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .period_i(period_i),
    .cnt_o   (cnt_w),
    .valley_o(valley_w),
    .peak_o  (peak_w)
  );

  pwm3_angle #(
    .ANG_W     (ANG_W),
    .HOLD_W    (HOLD_W),
    .SHIFT_STEP(SHIFT_STEP)
  ) u_ang (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .peak_i     (peak_w),
    .resync_i   (resync_i),
    .step_i     (step_i),
    .shift_tgt_i(shift_tgt_i),
    .holdoff_i  (holdoff_i),
    .pos_o      (pos_w),
    .shift_o    (shift_w)
  );

  assign base_w = pos_w + shift_w + XFMR_SHIFT;

  // outputs enabled from the first load after a start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pwm_on_q <= 1'b0;
    else if (!run)   pwm_on_q <= 1'b0;
    else if (peak_w) pwm_on_q <= 1'b1;
  end

  assign pwm_en = run && pwm_on_q;

  for (genvar gk = 0; gk < NPH; gk++) begin : g_ph
    pwm3_phase #(
      .CNT_W (CNT_W),
      .ANG_W (ANG_W),
      .IDX_W (IDX_W),
      .MAG_W (MAG_W),
      .PH_OFS(ANG_W'(gk * PH_STEP))
    ) u_ph (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valley_i(valley_w),
      .peak_i  (peak_w),
      .pwm_en_i(pwm_en),
      .base_i  (base_w),
      .mag_i   (mag_i[gk*MAG_W +: MAG_W]),
      .period_i(period_i),
      .cnt_i   (cnt_w),
      .cmp_o   (cmp_o[gk*CNT_W +: CNT_W]),
      .pwm_o   (pwm_o[gk])
    );
  end
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk #(
  parameter int CNT_W = 16,
  parameter int ANG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             peak,
  input logic             resync_i,
  input logic [CNT_W-1:0] period_i,
  input logic [ANG_W-1:0] step_i,
  input logic [CNT_W-1:0] cnt,
  input logic [3*CNT_W-1:0] cmp_o,
  input logic [2:0]       pwm_o,
  input logic [ANG_W-1:0] pos,
  input logic [ANG_W-1:0] shift
);
  assert_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (pwm_o == 3'b000));

  assert_carrier_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (cnt <= period_i));

  assert_cmp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peak |=> $stable(cmp_o));

  assert_cmp_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak |=> (cmp_o[0 +: CNT_W] <= $past(period_i)) &&
             (cmp_o[CNT_W +: CNT_W] <= $past(period_i)) &&
             (cmp_o[2*CNT_W +: CNT_W] <= $past(period_i)));

  assert_resync_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (pos == '0));

  assert_pos_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peak && !resync_i) |=> (pos == ANG_W'($past(pos) + $past(step_i))));

  assert_shift_at_peak_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !peak) |=> $stable(shift));

  assert_first_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> (pwm_o == 3'b000));
endmodule

bind pwm3_top pwm3_chk #(.CNT_W(CNT_W), .ANG_W(ANG_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run     (run),
  .peak    (peak_w),
  .resync_i(resync_i),
  .period_i(period_i),
  .step_i  (step_i),
  .cnt     (cnt_w),
  .cmp_o   (cmp_o),
  .pwm_o   (pwm_o),
  .pos     (pos_w),
  .shift   (shift_w)
);

// File: tb/sim_pwm3_top.sv
module sim_pwm3_top;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 40;
  localparam int STEP = 64;
  localparam int XFMR = 16'h1555;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        fault_i = 1'b0;
  logic        resync_i = 1'b0;
  logic [15:0] period_i = 16'(P);
  logic [15:0] step_i = '0;
  logic [47:0] mag_i = '0;
  logic [15:0] shift_tgt_i = '0;
  logic [15:0] holdoff_i = 16'd1000;
  logic [47:0] cmp_o;
  logic [2:0]  pwm_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm3_top u0 (.*);

  function automatic int sin_tab(int idx);
    real r;
    r = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(idx) / 256.0);
    return $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
  endfunction

  function automatic int exp_cmp(int base, int ph, int mag, int per);
    int arg, idx;
    longint s, sc, half, lvl;
    arg  = (base + XFMR + ph * 21845) & 16'hFFFF;
    idx  = arg >> 8;
    s    = longint'(sin_tab(idx));
    sc   = (s * longint'(mag)) >>> 15;
    half = longint'(per >> 1);
    lvl  = half + ((sc * half) >>> 15);
    if (lvl < 0) lvl = 0;
    if (lvl > per) lvl = per;
    return int'(lvl);
  endfunction

  function automatic int mag_of(int ph);
    return int'(mag_i[ph*16 +: 16]);
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_loads(string req, int base_pos, int shift);
    for (int ph = 0; ph < 3; ph++)
      check(req, int'(cmp_o[ph*16 +: 16]), exp_cmp(base_pos + shift, ph, mag_of(ph), P));
  endtask

  task automatic start_run();
    @(negedge clk_i);
    en_i = 1'b1;
  endtask

  task automatic stop_run();
    @(negedge clk_i);
    en_i = 1'b0;
    resync_i = 1'b0;
    fault_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  // to the negedge following the first load
  task automatic wait_first();
    repeat (P + 1) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wait_next();
    repeat (2 * P) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    check("R1 cmp", int'(cmp_o), 0);
    check("R1 pwm", int'(pwm_o), 0);
  endtask

  task automatic t_static();
    step_i = '0; holdoff_i = 16'd1000;
    mag_i = {16'd8192, 16'd32767, 16'd16384};
    start_run();
    repeat (P) @(posedge clk_i);
    @(negedge clk_i);
    check("R5 no load before peak", int'(cmp_o), 0);
    check("R10 low before load", int'(pwm_o), 0);
    @(posedge clk_i); @(negedge clk_i);
    check_loads("R3 R4 R5 first load", 0, 0);
    wait_next();
    check_loads("R3 second load", 0, 0);
    stop_run();
  endtask

  task automatic t_duty();
    int hi [3];
    step_i = '0; holdoff_i = 16'd1000;
    mag_i = {16'd20000, 16'd30000, 16'd25000};
    start_run();
    wait_first();
    for (int ph = 0; ph < 3; ph++) hi[ph] = 0;
    for (int c = 0; c < 2 * P; c++) begin
      for (int ph = 0; ph < 3; ph++) hi[ph] += int'(pwm_o[ph]);
      @(negedge clk_i);
    end
    for (int ph = 0; ph < 3; ph++) begin
      int cv;
      cv = exp_cmp(0, ph, mag_of(ph), P);
      check("R2 duty", hi[ph], (cv < P ? cv : P) + (cv > 1 ? cv - 1 : 0));
    end
    stop_run();
  endtask

  task automatic t_step();
    step_i = 16'd5000; holdoff_i = 16'd1000;
    mag_i = {16'd32767, 16'd32767, 16'd32767};
    start_run();
    wait_first();
    for (int k = 1; k <= 4; k++) begin
      check_loads("R6 position step", ((k - 1) * 5000) & 16'hFFFF, 0);
      wait_next();
    end
    stop_run();
  endtask

  task automatic t_shift();
    step_i = '0; holdoff_i = 16'd2; shift_tgt_i = 16'd160;
    mag_i = {16'd32767, 16'd32767, 16'd32767};
    start_run();
    wait_first();
    for (int k = 1; k <= 7; k++) begin
      int sh;
      sh = (k - 1 - 2) > 0 ? (k - 1 - 2) * STEP : 0;
      if (sh > 160) sh = 160;
      check_loads("R7 shift ramp", 0, sh);
      wait_next();
    end
    stop_run();
    shift_tgt_i = '0;
  endtask

  task automatic t_resync();
    step_i = 16'd4096; holdoff_i = 16'd1000;
    mag_i = {16'd32767, 16'd32767, 16'd32767};
    start_run();
    wait_first();
    wait_next();
    check_loads("R8 before resync", 4096, 0);
    resync_i = 1'b1;
    @(negedge clk_i);
    resync_i = 1'b0;
    repeat (2 * P - 1) @(posedge clk_i);
    @(negedge clk_i);
    check_loads("R8 after resync", 0, 0);
    wait_next();
    check_loads("R8 resumes", 4096, 0);
    stop_run();
  endtask

  task automatic t_sat();
    step_i = '0; holdoff_i = 16'd1000;
    mag_i = {16'd65535, 16'd65535, 16'd65535};
    start_run();
    wait_first();
    check_loads("R4 clamp", 0, 0);
    check("R4 phase2 clamped low", int'(cmp_o[32 +: 16]), 0);
    stop_run();
  endtask

  task automatic t_fault();
    step_i = 16'd3000; holdoff_i = 16'd0; shift_tgt_i = 16'd640;
    mag_i = {16'd16384, 16'd16384, 16'd16384};
    start_run();
    wait_first();
    wait_next();
    repeat (P) @(negedge clk_i);
    fault_i = 1'b1;
    #1;
    check("R9 fault forces low", int'(pwm_o), 0);
    @(negedge clk_i);
    fault_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R10 low after restart", int'(pwm_o), 0);
    stop_run();
    start_run();
    wait_first();
    check_loads("R9 state restarted", 0, 0);
    repeat (P) @(negedge clk_i);
    en_i = 1'b0;
    #1;
    check("R9 disable forces low", int'(pwm_o), 0);
    stop_run();
    shift_tgt_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_static();
    t_duty();
    t_step();
    t_shift();
    t_resync();
    t_sat();
    t_fault();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        errors++;
        vectors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule